// File: doc/BRIEF.md
# Multi-Channel Stream Bridge

This block joins a 32-bit memory-mapped processor bus to a set of outbound and inbound stream channels. Each channel owns a small FIFO. Software moves data by touching one data register per channel: a store places a word into that channel's outbound FIFO, and a load takes the oldest word out of that channel's inbound FIFO. The far side of every FIFO uses a valid/ready handshake, so a word moves only in a cycle where both are high.

Accesses never stall the bus. A store to a full outbound FIFO, or a load from an empty inbound FIFO, ends with a bus error instead, and leaves the FIFO untouched. Software can avoid those errors by reading a status word first. That word gives four flags per channel: room left, data present, and a half-full flag for each direction. A control word holds the unit's enable bit and reports, read-only, how many channels were built and how deep their FIFOs are. While the unit is disabled, every FIFO is held empty and both stream sides are silent.

Top module: `chan_stream_bridge`

## Requirements
- R1: The data register of channel i is at byte offset 0x20 + 4*i (i = 0..7). A store there pushes the write data into outbound FIFO i. A load there returns the head of inbound FIFO i and removes it. Both FIFOs keep first-in, first-out order.
- R2: A store to an implemented channel whose outbound FIFO is full is answered with bus_err and not with bus_ack, and the FIFO contents do not change.
- R3: A load from an implemented channel whose inbound FIFO is empty is answered with bus_err and returns zero data.
- R4: The status word at offset 0x08 has four fields. Bits 31:24 flag an outbound fill level of at least half the depth, and bits 23:16 flag the same for inbound. Bits 15:8 flag an outbound FIFO that is not full, and bits 7:0 flag an inbound FIFO that is not empty. In every field, bit k belongs to channel k, and the bits of channels that were not built read 0.
- R5: The control word at offset 0x00 reads as follows. Bits 3:0 hold the inbound channel count and bits 7:4 the outbound channel count. Bits 11:8 hold log2 of the inbound FIFO depth and bits 15:12 log2 of the outbound FIFO depth. Bit 31 is the enable, which can be written. All other bits read 0, and reset clears the enable.
- R6: A stream word moves only in a cycle where valid and ready are both high. tx_valid[i] is high exactly when the unit is enabled and outbound FIFO i holds data, and tx_data stays stable while a word waits. rx_ready[i] is high exactly when the unit is enabled and inbound FIFO i is not full.
- R7: While the enable is 0, every FIFO is held empty, tx_valid and rx_ready are all 0, and data-register accesses to implemented channels get bus_err. Words queued before a disable are gone after the unit is enabled again.
- R8: A data-register access to a channel index that was not built gets bus_ack. A load of it returns zero, and a store to it has no effect.
- R9: Every request gets exactly one of bus_ack or bus_err, in the cycle after it is presented, and no response appears without a request. Offsets outside the control, status and data registers read as zero, ignore stores, and are acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Single-cycle access request |
| bus_we | input | 1 | 1 = store, 0 = load |
| bus_addr | input | 8 | Byte offset; bits 1:0 are ignored |
| bus_wdata | input | 32 | Store data |
| bus_rdata | output | 32 | Load data, valid with the response |
| bus_ack | output | 1 | Access completed |
| bus_err | output | 1 | Access refused |
| tx_valid | output | NUM_TX | Per-channel outbound word present |
| tx_ready | input | NUM_TX | Per-channel outbound sink ready |
| tx_data | output | 32*NUM_TX | Outbound words, channel i at bits 32*i+31:32*i |
| rx_valid | input | NUM_RX | Per-channel inbound word present |
| rx_ready | output | NUM_RX | Per-channel inbound space available |
| rx_data | input | 32*NUM_RX | Inbound words, channel i at bits 32*i+31:32*i |

## Verification
The properties assume that bus_req is a single-cycle pulse per access and is never repeated in the cycle that carries the response. The bench keeps to this by leaving an idle cycle after every request. They also assume that a stream source keeps its word steady while valid is high and ready is low. The bench offers each inbound word for exactly one cycle and raises rx_valid only on channels it means to load. It never drives X on any input after reset.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
    localparam int WORD_W = 32;

    // register word indices (byte offset / 4)
    localparam logic [5:0] IDX_CTRL   = 6'h00;
    localparam logic [5:0] IDX_STATUS = 6'h02;
    // data window occupies byte offsets 0x20..0x3C
    localparam logic [2:0] DATA_PAGE  = 3'b001;
    localparam int         EN_BIT     = 31;

    typedef struct packed {
        logic              en;
        logic              ack;
        logic              err;
        logic [WORD_W-1:0] rdata;
    } regs_t;
endpackage

// File: rtl/sbr_fifo.sv
module sbr_fifo #(
    parameter int DW = 32,
    parameter int AW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic          full,
    output logic          empty,
    output logic          half
);
    localparam int DEPTH = 1 << AW;
    localparam int PW    = (AW > 0) ? AW : 1;
    localparam int LW    = AW + 1;

    typedef struct packed {
        logic [PW-1:0] wptr;
        logic [PW-1:0] rptr;
        logic [LW-1:0] level;
    } fifo_t;

    fifo_t st_d, st_q;
    logic [DW-1:0] mem_q [DEPTH];

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full  = (st_q.level == LW'(DEPTH));
    assign empty = (st_q.level == '0);
    assign half  = ((int'(st_q.level) * 2) >= DEPTH);
    assign head  = mem_q[st_q.rptr];

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else begin
            if (push && !full) st_d.wptr = step(st_q.wptr);
            if (pop && !empty) st_d.rptr = step(st_q.rptr);
            case ({push && !full, pop && !empty})
                2'b10:   st_d.level = st_q.level + 1'b1;
                2'b01:   st_d.level = st_q.level - 1'b1;
                default: st_d.level = st_q.level;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push && !full && !clr) mem_q[st_q.wptr] <= wdata;
    end

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !clr) |-> !full);
    // R3
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !clr) |-> !empty);
    // R1
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.level) <= DEPTH);
    // R7
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> empty);
endmodule

// File: rtl/sbr_regfile.sv
module sbr_regfile
    import sbr_pkg::*;
#(
    parameter int NUM_RX = 4,
    parameter int NUM_TX = 4,
    parameter int RX_AW  = 2,
    parameter int TX_AW  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req,
    input  logic                     we,
    input  logic [7:0]               addr,
    input  logic [WORD_W-1:0]        wdata,
    output logic [WORD_W-1:0]        rdata,
    output logic                     ack,
    output logic                     err,
    output logic                     enable,
    output logic [NUM_TX-1:0]        tx_push,
    output logic [NUM_RX-1:0]        rx_pop,
    input  logic [NUM_TX-1:0]        tx_full,
    input  logic [NUM_TX-1:0]        tx_half,
    input  logic [NUM_RX-1:0]        rx_empty,
    input  logic [NUM_RX-1:0]        rx_half,
    input  logic [NUM_RX*WORD_W-1:0] rx_head
);
    regs_t r_d, r_q;

    logic [2:0]        chan;
    logic              in_data;
    logic              impl_tx, impl_rx;
    logic              sel_full, sel_empty;
    logic [WORD_W-1:0] sel_head;
    logic [7:0]        txh8, rxh8, txf8, rxa8;
    logic [WORD_W-1:0] status_w, ctrl_w;

    assign chan    = addr[4:2];
    assign in_data = (addr[7:5] == DATA_PAGE);
    assign impl_tx = (int'(chan) < NUM_TX);
    assign impl_rx = (int'(chan) < NUM_RX);

    always_comb begin
        sel_full  = 1'b0;
        sel_empty = 1'b1;
        sel_head  = '0;
        txh8 = '0;
        txf8 = '0;
        rxh8 = '0;
        rxa8 = '0;
        for (int i = 0; i < NUM_TX; i++) begin
            txh8[i] = tx_half[i];
            txf8[i] = !tx_full[i];
            if (int'(chan) == i) sel_full = tx_full[i];
        end
        for (int i = 0; i < NUM_RX; i++) begin
            rxh8[i] = rx_half[i];
            rxa8[i] = !rx_empty[i];
            if (int'(chan) == i) begin
                sel_empty = rx_empty[i];
                sel_head  = rx_head[i*WORD_W +: WORD_W];
            end
        end
        status_w = {txh8, rxh8, txf8, rxa8};
        ctrl_w   = '0;
        ctrl_w[EN_BIT] = r_q.en;
        ctrl_w[15:12]  = 4'(TX_AW);
        ctrl_w[11:8]   = 4'(RX_AW);
        ctrl_w[7:4]    = 4'(NUM_TX);
        ctrl_w[3:0]    = 4'(NUM_RX);
    end

    always_comb begin
        r_d       = r_q;
        r_d.ack   = 1'b0;
        r_d.err   = 1'b0;
        r_d.rdata = '0;
        tx_push   = '0;
        rx_pop    = '0;
        if (req) begin
            if (in_data) begin
                if (we) begin
                    if (!impl_tx) begin
                        r_d.ack = 1'b1;
                    end else if (!r_q.en || sel_full) begin
                        r_d.err = 1'b1;
                    end else begin
                        r_d.ack = 1'b1;
                        for (int i = 0; i < NUM_TX; i++)
                            tx_push[i] = (int'(chan) == i);
                    end
                end else begin
                    if (!impl_rx) begin
                        r_d.ack = 1'b1;
                    end else if (!r_q.en || sel_empty) begin
                        r_d.err = 1'b1;
                    end else begin
                        r_d.ack   = 1'b1;
                        r_d.rdata = sel_head;
                        for (int i = 0; i < NUM_RX; i++)
                            rx_pop[i] = (int'(chan) == i);
                    end
                end
            end else begin
                r_d.ack = 1'b1;
                case (addr[7:2])
                    IDX_CTRL: begin
                        if (we) r_d.en = wdata[EN_BIT];
                        else    r_d.rdata = ctrl_w;
                    end
                    IDX_STATUS: begin
                        if (!we) r_d.rdata = status_w;
                    end
                    default: r_d.rdata = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rdata  = r_q.rdata;
    assign ack    = r_q.ack;
    assign err    = r_q.err;
    assign enable = r_q.en;

    // R9
    one_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> $onehot({ack, err}));
    // R9
    no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !(ack || err));
    // R2
    full_write_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && in_data && impl_tx && sel_full) |=> (err && !ack));
    // R3
    empty_read_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we && in_data && impl_rx && sel_empty) |=> (err && rdata == '0));
    // R8
    absent_chan_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && in_data && !(we ? impl_tx : impl_rx)) |=> (ack && rdata == '0));
endmodule

// File: rtl/chan_stream_bridge.sv
module chan_stream_bridge
    import sbr_pkg::*;
#(
    parameter int NUM_RX = 4,
    parameter int NUM_TX = 4,
    parameter int RX_AW  = 2,
    parameter int TX_AW  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_req,
    input  logic                     bus_we,
    input  logic [7:0]               bus_addr,
    input  logic [31:0]              bus_wdata,
    output logic [31:0]              bus_rdata,
    output logic                     bus_ack,
    output logic                     bus_err,
    output logic [NUM_TX-1:0]        tx_valid,
    input  logic [NUM_TX-1:0]        tx_ready,
    output logic [NUM_TX*32-1:0]     tx_data,
    input  logic [NUM_RX-1:0]        rx_valid,
    output logic [NUM_RX-1:0]        rx_ready,
    input  logic [NUM_RX*32-1:0]     rx_data
);
    logic                     en;
    logic [NUM_TX-1:0]        tx_push, tx_full, tx_empty, tx_half;
    logic [NUM_RX-1:0]        rx_pop, rx_full, rx_empty, rx_half;
    logic [NUM_RX*WORD_W-1:0] rx_head;

    sbr_regfile #(
        .NUM_RX (NUM_RX),
        .NUM_TX (NUM_TX),
        .RX_AW  (RX_AW),
        .TX_AW  (TX_AW)
    ) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (bus_req),
        .we       (bus_we),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .rdata    (bus_rdata),
        .ack      (bus_ack),
        .err      (bus_err),
        .enable   (en),
        .tx_push  (tx_push),
        .rx_pop   (rx_pop),
        .tx_full  (tx_full),
        .tx_half  (tx_half),
        .rx_empty (rx_empty),
        .rx_half  (rx_half),
        .rx_head  (rx_head)
    );

    for (genvar g = 0; g < NUM_TX; g++) begin : g_tx
        sbr_fifo #(.DW(WORD_W), .AW(TX_AW)) fifo_i (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (!en),
            .push  (tx_push[g]),
            .wdata (bus_wdata),
            .pop   (tx_valid[g] && tx_ready[g]),
            .head  (tx_data[g*WORD_W +: WORD_W]),
            .full  (tx_full[g]),
            .empty (tx_empty[g]),
            .half  (tx_half[g])
        );
        assign tx_valid[g] = en && !tx_empty[g];

        // R6
        tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (tx_valid[g] && !tx_ready[g]) |=>
                (!en || (tx_valid[g] && $stable(tx_data[g*WORD_W +: WORD_W]))));
    end

    for (genvar g = 0; g < NUM_RX; g++) begin : g_rx
        sbr_fifo #(.DW(WORD_W), .AW(RX_AW)) fifo_i (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (!en),
            .push  (rx_valid[g] && rx_ready[g]),
            .wdata (rx_data[g*WORD_W +: WORD_W]),
            .pop   (rx_pop[g]),
            .head  (rx_head[g*WORD_W +: WORD_W]),
            .full  (rx_full[g]),
            .empty (rx_empty[g]),
            .half  (rx_half[g])
        );
        assign rx_ready[g] = en && !rx_full[g];
    end

    // R7
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (tx_valid == '0 && rx_ready == '0));
endmodule

// File: tb/chan_stream_bridge_tb_top.sv
module chan_stream_bridge_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NRX = 4;
    localparam int NTX = 4;
    localparam int WATCHDOG = 20000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_req = 1'b0;
    logic             bus_we = 1'b0;
    logic [7:0]       bus_addr = '0;
    logic [31:0]      bus_wdata = '0;
    logic [31:0]      bus_rdata;
    logic             bus_ack, bus_err;
    logic [NTX-1:0]   tx_valid;
    logic [NTX-1:0]   tx_ready = '0;
    logic [NTX*32-1:0] tx_data;
    logic [NRX-1:0]   rx_valid = '0;
    logic [NRX-1:0]   rx_ready;
    logic [NRX*32-1:0] rx_data = '0;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    typedef struct {
        logic        err;
        logic        cmp;
        logic [31:0] data;
        string       tag;
    } resp_t;

    resp_t       resp_q[$];
    logic [35:0] tx_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    chan_stream_bridge #(.NUM_RX(NRX), .NUM_TX(NTX), .RX_AW(2), .TX_AW(2)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_err(bus_err),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // driver: queue the expected response, then present one request
    task automatic bus_op(input logic we, input logic [7:0] addr, input logic [31:0] wd,
                          input logic exp_err, input logic cmp, input logic [31:0] exp_d,
                          input string tag);
        resp_t e;
        e.err = exp_err; e.cmp = cmp; e.data = exp_d; e.tag = tag;
        resp_q.push_back(e);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = addr; bus_wdata = wd;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rx_send(input int ch, input logic [31:0] d);
        @(negedge clk);
        rx_valid[ch] = 1'b1;
        rx_data[ch*32 +: 32] = d;
        @(negedge clk);
        rx_valid[ch] = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // monitor: bus responses and outbound stream words
    always @(negedge clk) begin
        if (rst_n && (bus_ack || bus_err)) begin
            if (resp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R9: unexpected response ack=%0b err=%0b expected none", bus_ack, bus_err);
            end else begin
                resp_t e;
                e = resp_q.pop_front();
                chk({e.tag, " err"}, {31'b0, bus_err}, {31'b0, e.err});
                chk({e.tag, " ack"}, {31'b0, bus_ack}, {31'b0, !e.err});
                if (e.cmp) chk({e.tag, " data"}, bus_rdata, e.data);
            end
        end
        for (int i = 0; i < NTX; i++) begin
            if (rst_n && tx_valid[i] && tx_ready[i]) begin
                if (tx_q.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R6: unexpected tx word 0x%08h on channel %0d expected none",
                             tx_data[i*32 +: 32], i);
                end else begin
                    logic [35:0] t;
                    t = tx_q.pop_front();
                    chk("R1 tx channel", i, {28'b0, t[35:32]});
                    chk("R1 tx order", tx_data[i*32 +: 32], t[31:0]);
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cyc, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        idle(3);
        // reset state, R7 / R9
        chk("R9 reset ack", {31'b0, bus_ack}, 32'd0);
        chk("R9 reset err", {31'b0, bus_err}, 32'd0);
        chk("R7 reset tx_valid", {28'b0, tx_valid}, 32'd0);
        chk("R7 reset rx_ready", {28'b0, rx_ready}, 32'd0);
        rst_n = 1'b1;
        idle(2);

        // R5 control word while disabled
        bus_op(0, 8'h00, 0, 0, 1, 32'h0000_2244, "R5 ctrl disabled");
        // R7 data access while disabled
        bus_op(1, 8'h20, 32'h1, 1, 0, 0, "R7 write disabled");
        bus_op(0, 8'h24, 0, 1, 1, 0, "R7 read disabled");
        chk("R7 tx_valid after disabled write", {28'b0, tx_valid}, 32'd0);

        // enable
        bus_op(1, 8'h00, 32'h8000_0000, 0, 0, 0, "R5 ctrl write");
        bus_op(0, 8'h00, 0, 0, 1, 32'h8000_2244, "R5 ctrl enabled");
        bus_op(0, 8'h08, 0, 0, 1, 32'h0000_0F00, "R4 status idle");
        chk("R6 rx_ready enabled", {28'b0, rx_ready}, 32'h0000_000F);

        // R1 / R2 fill outbound channel 0
        for (int k = 0; k < 4; k++) begin
            bus_op(1, 8'h20, 32'hA000_0000 + k, 0, 0, 0, "R1 tx push");
            tx_q.push_back({4'd0, 32'hA000_0000 + k});
        end
        bus_op(1, 8'h20, 32'hDEAD_BEEF, 1, 0, 0, "R2 write full");
        bus_op(0, 8'h08, 0, 0, 1, 32'h0100_0E00, "R4 status tx0 full");
        chk("R6 tx_valid ch0", {28'b0, tx_valid}, 32'h0000_0001);
        chk("R6 tx_data head", tx_data[31:0], 32'hA000_0000);

        // R6 drain through the handshake; overflow word must not appear
        @(negedge clk); tx_ready[0] = 1'b1;
        idle(6);
        tx_ready[0] = 1'b0;
        chk("R2 tx queue drained", tx_q.size(), 32'd0);
        chk("R6 tx_valid after drain", {28'b0, tx_valid}, 32'd0);

        // R1 / R4 / R6 inbound channel 1
        rx_send(1, 32'hB000_0001);
        rx_send(1, 32'hB000_0002);
        rx_send(1, 32'hB000_0003);
        bus_op(0, 8'h08, 0, 0, 1, 32'h0002_0F02, "R4 status rx1 three");
        rx_send(1, 32'hB000_0004);
        chk("R6 rx_ready ch1 full", {28'b0, rx_ready}, 32'h0000_000D);
        rx_send(1, 32'hB000_0005);
        for (int k = 1; k <= 4; k++)
            bus_op(0, 8'h24, 0, 0, 1, 32'hB000_0000 + k, "R1 rx pop");
        bus_op(0, 8'h24, 0, 1, 1, 32'h0, "R3 read empty");
        bus_op(0, 8'h08, 0, 0, 1, 32'h0000_0F00, "R4 status after pops");

        // R8 channel index not built
        bus_op(0, 8'h38, 0, 0, 1, 32'h0, "R8 absent read");
        bus_op(1, 8'h38, 32'h1234_5678, 0, 0, 0, "R8 absent write");
        bus_op(0, 8'h08, 0, 0, 1, 32'h0000_0F00, "R8 status unchanged");
        chk("R8 tx_valid unchanged", {28'b0, tx_valid}, 32'd0);
        // R9 unused offset
        bus_op(1, 8'h04, 32'hFFFF_FFFF, 0, 0, 0, "R9 reserved write");
        bus_op(0, 8'h04, 0, 0, 1, 32'h0, "R9 reserved read");

        // R7 disable flushes queued words
        bus_op(1, 8'h28, 32'hC0DE_0002, 0, 0, 0, "R1 tx push ch2");
        chk("R6 tx_valid ch2", {28'b0, tx_valid}, 32'h0000_0004);
        rx_send(3, 32'hE000_0003);
        bus_op(1, 8'h00, 32'h0, 0, 0, 0, "R7 disable");
        chk("R7 tx_valid disabled", {28'b0, tx_valid}, 32'd0);
        chk("R7 rx_ready disabled", {28'b0, rx_ready}, 32'd0);
        bus_op(1, 8'h00, 32'h8000_0000, 0, 0, 0, "R7 re-enable");
        chk("R7 tx flushed", {28'b0, tx_valid}, 32'd0);
        bus_op(0, 8'h08, 0, 0, 1, 32'h0000_0F00, "R7 status flushed");
        bus_op(0, 8'h2C, 0, 1, 1, 32'h0, "R7 rx flushed");

        idle(3);
        chk("R9 all responses seen", resp_q.size(), 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule